// File: doc/BRIEF.md
# Performance Monitoring Counter Unit

This block counts activity inside an accelerator so software can profile it. It has four 32-bit event counters and one 48-bit cycle counter. Each event counter has a selector register that names one line of the incoming event-pulse vector, and it adds one in every cycle where that line is high. The cycle counter counts clock cycles, but only between a programmable start event and a programmable stop event. A global enable and a per-counter enable gate all counting. When any counter wraps, it raises its overflow flag. A single interrupt line is high while any overflow flag is set whose interrupt enable is also set.

Software reaches the block through a simple synchronous register bus: byte address, write strobe, write data, and combinational read data. The enable, overflow and interrupt-enable state is each held as one mask. Each mask has a write-one-to-set register and a write-one-to-clear register, and both return the mask when read. In every mask, bits 0 to 3 stand for the event counters and bit 31 stands for the cycle counter. A software-increment register lets a driver bump selected event counters by hand. The two halves of the cycle counter are written through a staging register, so that both halves change on the same edge.

Top module: `perf_mon_unit`

## Requirements
- R1: Control register at 0x180. Bit 0 is a read/write global enable. Writing 1 to bit 1 zeroes all event counters, and writing 1 to bit 2 zeroes the cycle counter. Bits 1 and 2 always read 0. Bits [15:11] read the event counter count (4). All other bits read 0, so the reset value reads 0x2000.
- R2: Register layout, by byte address:
  - 0x184/0x188: enable set/clear.
  - 0x18C/0x190: overflow set/clear.
  - 0x194/0x198: interrupt-enable set/clear.
  - 0x1A0/0x1A4: cycle counter low/high word.
  - 0x1A8: cycle configuration.
  - 0x1AC: software increment.
  - 0x300+4k: value of event counter k.
  - 0x380+4k: event selector of counter k (bits [9:0], read back).
  - Unmapped addresses read 0.
- R3: Writing 1 to bit k of the enable-set register enables a counter, and writing 1 to bit k of the enable-clear register disables it. Bits 0..3 are the event counters and bit 31 is the cycle counter. Both registers read the current mask, and bits that are not implemented read 0.
- R4: Event counter k adds one on each clock edge where its selected event input is high, the global enable is 1 and its enable bit is 1. Otherwise it holds its value. A selector value of 16 or more (at or above the number of event inputs) never counts.
- R5: Writing 1 to bit k of the software-increment register adds one to event counter k, but only if that counter is active (global enable and its own enable are both 1). If the selected event is high in the same cycle, the counter adds two.
- R6: When a counter wraps from all ones to zero, its overflow bit is set. Overflow bits can also be set and cleared by software through the set/clear pair. In the same cycle, a hardware set wins over a software clear.
- R7: The interrupt output is high exactly when some overflow bit and the matching interrupt-enable bit are both 1. Interrupt enable uses its own set/clear pair with the same bit mapping.
- R8: The cycle configuration register holds the start event number in bits [9:0] and the stop event number in bits [25:16]. A start pulse sets a running flag and a stop pulse clears it; if both arrive in the same cycle, the stop wins. The counter adds one on each edge where the flag is set, the global enable is 1 and enable bit 31 is 1. As a result, a start pulse at edge n and a stop pulse at edge n+d give a count of d.
- R9: The cycle counter is 48 bits wide. Bits [31:16] of the high word read 0. Wrapping from 2^48-1 to 0 sets overflow bit 31.
- R10: A write to the low word of the cycle counter only stages the value. A later write to the high word loads the high 16 bits together with the staged low word, in one cycle.
- R11: A software write to a counter value takes precedence over a hardware increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_pulse | input | 16 | One-cycle event pulses from the host design |
| irq | output | 1 | Overflow interrupt |

## Verification
Some properties are checked on every cycle:
- The control readback shape, including the write-only bits reading 0 and the counter-count field.
- The effect of enable set and clear writes on the following cycle.
- Inactive event counters holding their value.
- Every wrap from all ones to zero leaving the overflow bit set.
- The interrupt only ever being high with both an overflow and an enable present.
- The cycle high word's upper bits reading 0.
- A low-word write alone leaving a stopped cycle counter untouched.

Other behaviour needs the bench's scenarios to show it:
- Exact event counts over a sweep of pulse patterns.
- The start-to-stop cycle count for several gaps.
- Stop winning over start.
- The add-two case.
- Write-over-increment priority.
- The hardware-set-over-clear race.
- The 48-bit wrap.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int unsigned ADDR_W   = 10;
    localparam int unsigned EVT_ID_W = 10;
    localparam int unsigned CYC_BIT  = 31;
    localparam int unsigned REGION_LSB = 7;
    localparam int unsigned SLOT_W   = 5;

    // control block byte offsets
    localparam logic [ADDR_W-1:0] A_CTRL    = 10'h180;
    localparam logic [ADDR_W-1:0] A_EN_SET  = 10'h184;
    localparam logic [ADDR_W-1:0] A_EN_CLR  = 10'h188;
    localparam logic [ADDR_W-1:0] A_OVF_SET = 10'h18C;
    localparam logic [ADDR_W-1:0] A_OVF_CLR = 10'h190;
    localparam logic [ADDR_W-1:0] A_IRQ_SET = 10'h194;
    localparam logic [ADDR_W-1:0] A_IRQ_CLR = 10'h198;
    localparam logic [ADDR_W-1:0] A_CYC_LO  = 10'h1A0;
    localparam logic [ADDR_W-1:0] A_CYC_HI  = 10'h1A4;
    localparam logic [ADDR_W-1:0] A_CYC_CFG = 10'h1A8;
    localparam logic [ADDR_W-1:0] A_SWINC   = 10'h1AC;
    // arrays
    localparam logic [ADDR_W-1:0] A_CNT_BASE = 10'h300;
    localparam logic [ADDR_W-1:0] A_SEL_BASE = 10'h380;

    typedef struct packed {
        logic [EVT_ID_W-1:0] stop_id;
        logic [EVT_ID_W-1:0] start_id;
    } cyc_cfg_t;

    typedef enum logic [1:0] {
        MOP_NONE = 2'd0,
        MOP_SET  = 2'd1,
        MOP_CLR  = 2'd2
    } mask_op_e;

    // Look up one event line; ids at or above n_evt never fire (n_evt <= 64).
    function automatic logic evt_hit(logic [63:0] vec, logic [EVT_ID_W-1:0] id,
                                     int unsigned n_evt);
        logic [31:0] wide_id;
        wide_id = {{(32-EVT_ID_W){1'b0}}, id};
        if (wide_id < n_evt) return vec[id[5:0]];
        return 1'b0;
    endfunction

endpackage

// File: rtl/pmu_mask_reg.sv
module pmu_mask_reg
    import pmu_pkg::*;
#(
    parameter logic [31:0] IMPL = 32'hFFFF_FFFF
) (
    input  logic        clk,
    input  logic        rst,
    input  mask_op_e    op,
    input  logic [31:0] wdata,
    input  logic [31:0] hw_set,
    output logic [31:0] q
);

    logic [31:0] set_bits;
    logic [31:0] clr_bits;
    logic [31:0] q_next;

    always_comb begin
        set_bits = (op == MOP_SET) ? wdata : 32'h0;
        clr_bits = (op == MOP_CLR) ? wdata : 32'h0;
        // hardware set is applied last so it wins over a clear
        q_next   = (((q | set_bits) & ~clr_bits) | hw_set) & IMPL;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 32'h0;
        else     q <= q_next;
    end

endmodule

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter
    import pmu_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned NUM_EVT = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                active,
    input  logic [NUM_EVT-1:0]  evt_pulse,
    input  logic                sw_inc,
    input  logic                clr,
    input  logic                cnt_we,
    input  logic                sel_we,
    input  logic [31:0]         wdata,
    output logic [CNT_W-1:0]    count,
    output logic [EVT_ID_W-1:0] sel,
    output logic                wrap
);

    logic       hit;
    logic [1:0] step;
    logic [CNT_W:0] sum;

    always_comb begin
        hit  = evt_hit(64'(evt_pulse), sel, NUM_EVT);
        step = active ? ({1'b0, hit} + {1'b0, sw_inc}) : 2'd0;
        sum  = {1'b0, count} + (CNT_W+1)'(step);
        wrap = sum[CNT_W] & ~clr & ~cnt_we;
    end

    always_ff @(posedge clk) begin
        if (rst)         count <= '0;
        else if (clr)    count <= '0;
        else if (cnt_we) count <= wdata[CNT_W-1:0];
        else             count <= sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)         sel <= '0;
        else if (sel_we) sel <= wdata[EVT_ID_W-1:0];
    end

endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter
    import pmu_pkg::*;
#(
    parameter int unsigned CYC_W   = 48,
    parameter int unsigned NUM_EVT = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               clr,
    input  logic               lo_we,
    input  logic               hi_we,
    input  logic               cfg_we,
    input  logic [31:0]        wdata,
    output logic [CYC_W-1:0]   count,
    output cyc_cfg_t           cfg,
    output logic               wrap
);

    localparam int unsigned HI_W = CYC_W - 32;

    logic [31:0] stage_lo;
    logic        run;
    logic        start_hit;
    logic        stop_hit;
    logic        inc;

    always_comb begin
        start_hit = evt_hit(64'(evt_pulse), cfg.start_id, NUM_EVT);
        stop_hit  = evt_hit(64'(evt_pulse), cfg.stop_id, NUM_EVT);
        inc       = active & run;
        wrap      = inc & (&count) & ~clr & ~hi_we;
    end

    always_ff @(posedge clk) begin
        if (rst)           run <= 1'b0;
        else if (stop_hit) run <= 1'b0;
        else if (start_hit) run <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)        stage_lo <= '0;
        else if (lo_we) stage_lo <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)        count <= '0;
        else if (clr)   count <= '0;
        else if (hi_we) count <= {wdata[HI_W-1:0], stage_lo};
        else if (inc)   count <= count + CYC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)         cfg <= '0;
        else if (cfg_we) cfg <= '{stop_id: wdata[16 +: EVT_ID_W], start_id: wdata[EVT_ID_W-1:0]};
    end

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
    import pmu_pkg::*;
#(
    parameter int unsigned NUM_CNT = 4,
    parameter int unsigned NUM_EVT = 16,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned CYC_W   = 48
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic               irq
);

    localparam logic [31:0] IMPL_MASK = (32'h1 << CYC_BIT) | ((32'h1 << NUM_CNT) - 32'h1);
    localparam int unsigned HI_W = CYC_W - 32;

    logic                glob_en;
    logic [31:0]         en_q, ovf_q, inten_q;
    logic [31:0]         ovf_hw;
    logic                wr_ctrl, evt_clr, cyc_clr;
    logic                in_cnt, in_sel;
    logic [SLOT_W-1:0]   slot;
    logic [NUM_CNT-1:0]  cnt_we, sel_we, cnt_active, evt_wrap;
    logic [CNT_W-1:0]    cnt_val [NUM_CNT];
    logic [EVT_ID_W-1:0] sel_val [NUM_CNT];
    logic [NUM_CNT*CNT_W-1:0] cnt_flat;
    logic [CYC_W-1:0]    cyc_cnt;
    cyc_cfg_t            cyc_cfg;
    logic                cyc_active, cyc_wrap;
    mask_op_e            en_op, ovf_op, int_op;

    // ---- write decode ----
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == A_CTRL);
        evt_clr = wr_ctrl && bus_wdata[1];
        cyc_clr = wr_ctrl && bus_wdata[2];
        in_cnt  = (bus_addr[ADDR_W-1:REGION_LSB] == A_CNT_BASE[ADDR_W-1:REGION_LSB]) && (bus_addr[1:0] == 2'b00);
        in_sel  = (bus_addr[ADDR_W-1:REGION_LSB] == A_SEL_BASE[ADDR_W-1:REGION_LSB]) && (bus_addr[1:0] == 2'b00);
        slot    = bus_addr[2 +: SLOT_W];
        en_op   = !bus_wr ? MOP_NONE : (bus_addr == A_EN_SET)  ? MOP_SET : (bus_addr == A_EN_CLR)  ? MOP_CLR : MOP_NONE;
        ovf_op  = !bus_wr ? MOP_NONE : (bus_addr == A_OVF_SET) ? MOP_SET : (bus_addr == A_OVF_CLR) ? MOP_CLR : MOP_NONE;
        int_op  = !bus_wr ? MOP_NONE : (bus_addr == A_IRQ_SET) ? MOP_SET : (bus_addr == A_IRQ_CLR) ? MOP_CLR : MOP_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst)          glob_en <= 1'b0;
        else if (wr_ctrl) glob_en <= bus_wdata[0];
    end

    // ---- mask registers ----
    pmu_mask_reg #(.IMPL(IMPL_MASK)) u_en_mask (
        .clk(clk), .rst(rst), .op(en_op), .wdata(bus_wdata), .hw_set(32'h0), .q(en_q));
    pmu_mask_reg #(.IMPL(IMPL_MASK)) u_ovf_mask (
        .clk(clk), .rst(rst), .op(ovf_op), .wdata(bus_wdata), .hw_set(ovf_hw), .q(ovf_q));
    pmu_mask_reg #(.IMPL(IMPL_MASK)) u_int_mask (
        .clk(clk), .rst(rst), .op(int_op), .wdata(bus_wdata), .hw_set(32'h0), .q(inten_q));

    // ---- event counters ----
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        assign cnt_we[k]     = bus_wr && in_cnt && (slot == SLOT_W'(k));
        assign sel_we[k]     = bus_wr && in_sel && (slot == SLOT_W'(k));
        assign cnt_active[k] = glob_en && en_q[k];
        assign cnt_flat[k*CNT_W +: CNT_W] = cnt_val[k];

        pmu_evt_counter #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) u_cnt (
            .clk(clk), .rst(rst), .active(cnt_active[k]), .evt_pulse(evt_pulse),
            .sw_inc(bus_wr && (bus_addr == A_SWINC) && bus_wdata[k]),
            .clr(evt_clr), .cnt_we(cnt_we[k]), .sel_we(sel_we[k]), .wdata(bus_wdata),
            .count(cnt_val[k]), .sel(sel_val[k]), .wrap(evt_wrap[k]));
    end

    // ---- cycle counter ----
    assign cyc_active = glob_en && en_q[CYC_BIT];

    pmu_cycle_counter #(.CYC_W(CYC_W), .NUM_EVT(NUM_EVT)) u_cyc (
        .clk(clk), .rst(rst), .active(cyc_active), .evt_pulse(evt_pulse), .clr(cyc_clr),
        .lo_we(bus_wr && (bus_addr == A_CYC_LO)), .hi_we(bus_wr && (bus_addr == A_CYC_HI)),
        .cfg_we(bus_wr && (bus_addr == A_CYC_CFG)), .wdata(bus_wdata),
        .count(cyc_cnt), .cfg(cyc_cfg), .wrap(cyc_wrap));

    always_comb begin
        ovf_hw = 32'h0;
        ovf_hw[NUM_CNT-1:0] = evt_wrap;
        ovf_hw[CYC_BIT]     = cyc_wrap;
    end

    assign irq = |(ovf_q & inten_q);

    // ---- read mux ----
    always_comb begin
        bus_rdata = 32'h0;
        if (in_cnt) begin
            for (int k = 0; k < NUM_CNT; k++)
                if (slot == SLOT_W'(k)) bus_rdata = 32'(cnt_val[k]);
        end else if (in_sel) begin
            for (int k = 0; k < NUM_CNT; k++)
                if (slot == SLOT_W'(k)) bus_rdata = 32'(sel_val[k]);
        end else begin
            case (bus_addr)
                A_CTRL:               bus_rdata = {16'h0, 5'(NUM_CNT), 10'h0, glob_en};
                A_EN_SET, A_EN_CLR:   bus_rdata = en_q;
                A_OVF_SET, A_OVF_CLR: bus_rdata = ovf_q;
                A_IRQ_SET, A_IRQ_CLR: bus_rdata = inten_q;
                A_CYC_LO:             bus_rdata = cyc_cnt[31:0];
                A_CYC_HI:             bus_rdata = 32'(cyc_cnt[CYC_W-1:32]);
                A_CYC_CFG:            bus_rdata = {{(16-EVT_ID_W){1'b0}}, cyc_cfg.stop_id,
                                                   {(16-EVT_ID_W){1'b0}}, cyc_cfg.start_id};
                default:              bus_rdata = 32'h0;
            endcase
        end
    end

endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
    import pmu_pkg::*;
#(
    parameter int unsigned NUM_CNT = 4,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned CYC_W   = 48
) (
    input logic                     clk,
    input logic                     rst,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_wr,
    input logic [31:0]              bus_wdata,
    input logic [31:0]              bus_rdata,
    input logic                     irq,
    input logic [31:0]              en_q,
    input logic [31:0]              ovf_q,
    input logic [31:0]              inten_q,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
    input logic [NUM_CNT-1:0]       cnt_active,
    input logic [NUM_CNT-1:0]       cnt_we,
    input logic                     evt_clr,
    input logic [CYC_W-1:0]         cyc_cnt,
    input logic                     cyc_active,
    input logic                     cyc_clr
);

    localparam logic [31:0] IMPL_MASK = (32'h1 << CYC_BIT) | ((32'h1 << NUM_CNT) - 32'h1);

    // R1
    ctrl_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_CTRL) |-> (bus_rdata[31:1] == {16'h0, 5'(NUM_CNT), 10'h0}));

    // R1
    ctrl_en_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_CTRL && en_q[0]) |-> (bus_rdata[0] == cnt_active[0]));

    // R3
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_EN_SET) |=> ((en_q & $past(bus_wdata) & IMPL_MASK) == ($past(bus_wdata) & IMPL_MASK)));

    // R3
    en_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_EN_CLR) |=> ((en_q & $past(bus_wdata)) == 32'h0));

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_chk
        // R4
        idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!cnt_active[k] && !cnt_we[k] && !evt_clr) |=> $stable(cnt_flat[k*CNT_W +: CNT_W]));

        // R6
        wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
            (cnt_flat[k*CNT_W +: CNT_W] == '1 && !cnt_we[k] && !evt_clr) ##1 (cnt_flat[k*CNT_W +: CNT_W] == '0)
            |-> ovf_q[k]);
    end

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ovf_q != 32'h0 && inten_q != 32'h0));

    // R9
    cyc_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_CYC_HI) |-> (bus_rdata[31:16] == 16'h0));

    // R10
    lo_stage_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CYC_LO && !cyc_active && !cyc_clr) |=> $stable(cyc_cnt));

endmodule

bind perf_mon_unit pmu_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_pmu_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .en_q(en_q), .ovf_q(ovf_q), .inten_q(inten_q),
    .cnt_flat(cnt_flat), .cnt_active(cnt_active), .cnt_we(cnt_we), .evt_clr(evt_clr),
    .cyc_cnt(cyc_cnt), .cyc_active(cyc_active), .cyc_clr(cyc_clr));

// File: tb/test_perf_mon_unit.sv
`timescale 1ns/1ps
module test_perf_mon_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] evt_pulse = '0;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    perf_mon_unit i_perf_mon_unit (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .evt_pulse(evt_pulse), .irq(irq));

    localparam logic [9:0] CTRL = 10'h180, ENS = 10'h184, ENC = 10'h188, OVS = 10'h18C,
                           OVC = 10'h190, IRS = 10'h194, IRC = 10'h198, CLO = 10'h1A0,
                           CHI = 10'h1A4, CCFG = 10'h1A8, SWI = 10'h1AC;

    function automatic logic [9:0] cnt_a(int k); return 10'h300 + 10'(4*k); endfunction
    function automatic logic [9:0] sel_a(int k); return 10'h380 + 10'(4*k); endfunction

    task automatic tick(); @(negedge clk); endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick(); bus_wr = 1'b0;
    endtask

    task automatic wr_evt(input logic [9:0] a, input logic [31:0] d, input logic [15:0] ev);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; evt_pulse = ev; tick();
        bus_wr = 1'b0; evt_pulse = '0;
    endtask

    task automatic pulse(input logic [15:0] ev);
        evt_pulse = ev; tick(); evt_pulse = '0;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_rd(input string tag, input logic [9:0] a, input logic [31:0] exp);
        bus_addr = a; #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        #1; check(tag, {31'h0, irq}, {31'h0, exp});
    endtask

    initial begin
        logic [31:0] exp_cnt [4];
        logic [15:0] pat;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // reset state
        chk_rd("R1 reset ctrl", CTRL, 32'h0000_2000);
        chk_rd("R3 reset enable", ENS, 32'h0);
        chk_irq("R7 reset irq", 1'b0);

        // control register readback
        wr(CTRL, 32'hFFFF_FFFF);
        chk_rd("R1 ctrl all-ones readback", CTRL, 32'h0000_2001);
        wr(CTRL, 32'h0);
        chk_rd("R1 ctrl zero readback", CTRL, 32'h0000_2000);

        // enable pair
        wr(ENS, 32'hFFFF_FFFF);
        chk_rd("R3 enable set view", ENS, 32'h8000_000F);
        wr(ENC, 32'h8000_0004);
        chk_rd("R3 enable clr view", ENC, 32'h0000_000B);
        chk_rd("R2 unmapped", 10'h1B0, 32'h0);

        // selectors: counter k watches event k+1
        for (int k = 0; k < 4; k++) wr(sel_a(k), 32'(k + 1));
        chk_rd("R2 selector readback", sel_a(2), 32'd3);

        // counting sweep
        wr(CTRL, 32'h1);
        for (int k = 0; k < 4; k++) exp_cnt[k] = 0;
        for (int i = 0; i < 40; i++) begin
            pat = 16'(i * 40503 + 7);
            pulse(pat);
            for (int k = 0; k < 4; k++)
                if (k != 2 && pat[k+1]) exp_cnt[k]++;
        end
        for (int k = 0; k < 4; k++) chk_rd($sformatf("R4 sweep counter %0d", k), cnt_a(k), exp_cnt[k]);

        // out-of-range selector never counts
        wr(sel_a(0), 32'd16);
        pulse(16'hFFFF);
        chk_rd("R4 selector out of range", cnt_a(0), exp_cnt[0]);
        chk_rd("R4 in-range still counts", cnt_a(1), exp_cnt[1] + 1);

        // global disable holds
        wr(CTRL, 32'h0);
        pulse(16'hFFFF);
        chk_rd("R4 global disable holds", cnt_a(1), exp_cnt[1] + 1);

        // event counter reset
        wr(CTRL, 32'h3);
        chk_rd("R1 event reset c1", cnt_a(1), 32'h0);
        chk_rd("R1 event reset c3", cnt_a(3), 32'h0);
        chk_rd("R1 reset bit reads 0", CTRL, 32'h0000_2001);

        // software increment
        wr(SWI, 32'h0000_000F);
        chk_rd("R5 sw inc active", cnt_a(1), 32'd1);
        chk_rd("R5 sw inc disabled ignored", cnt_a(2), 32'd0);
        wr_evt(SWI, 32'h2, 16'h0004);
        chk_rd("R5 sw inc plus event", cnt_a(1), 32'd3);

        // write beats increment
        wr_evt(cnt_a(1), 32'd100, 16'h0004);
        chk_rd("R11 write wins", cnt_a(1), 32'd100);

        // overflow and interrupt
        wr(cnt_a(1), 32'hFFFF_FFFF);
        pulse(16'h0004);
        chk_rd("R6 wrap value", cnt_a(1), 32'h0);
        chk_rd("R6 wrap flag", OVS, 32'h2);
        chk_irq("R7 masked irq", 1'b0);
        wr(IRS, 32'h2);
        chk_irq("R7 irq asserted", 1'b1);
        wr(OVC, 32'h2);
        chk_irq("R7 irq after ovf clear", 1'b0);
        chk_rd("R6 ovf cleared", OVC, 32'h0);
        wr(OVS, 32'h8);
        chk_rd("R6 ovf sw set", OVS, 32'h8);
        chk_irq("R7 other bit masked", 1'b0);
        wr(IRS, 32'h8);
        chk_irq("R7 irq bit3", 1'b1);
        wr(IRC, 32'hFFFF_FFFF);
        chk_irq("R7 irq disabled", 1'b0);
        chk_rd("R7 inten cleared", IRS, 32'h0);
        wr(OVC, 32'hFFFF_FFFF);
        wr(cnt_a(1), 32'hFFFF_FFFF);
        wr_evt(OVC, 32'h2, 16'h0004);
        chk_rd("R6 hw set beats clear", OVS, 32'h2);
        wr(OVC, 32'hFFFF_FFFF);

        // cycle counter start/stop
        wr(CCFG, 32'h0005_0003);
        chk_rd("R8 cfg readback", CCFG, 32'h0005_0003);
        wr(ENS, 32'h8000_0000);
        foreach (exp_cnt[j]) exp_cnt[j] = 0;
        for (int g = 0; g < 3; g++) begin
            int d;
            d = g * 3 + (g == 2 ? 3 : 0);
            wr(CTRL, 32'h5);
            pulse(16'h0008);
            repeat (d) tick();
            pulse(16'h0020);
            repeat (3) tick();
            chk_rd($sformatf("R8 window gap %0d", d), CLO, 32'(d + 1));
        end
        wr(CTRL, 32'h5);
        pulse(16'h0028);
        repeat (4) tick();
        chk_rd("R8 stop wins over start", CLO, 32'h0);

        // staged write
        wr(ENC, 32'h8000_0000);
        wr(CLO, 32'h1234_5678);
        chk_rd("R10 low write staged only", CLO, 32'h0);
        wr(CHI, 32'hFFFF_00AB);
        chk_rd("R10 low committed", CLO, 32'h1234_5678);
        chk_rd("R9 high upper bits zero", CHI, 32'h0000_00AB);

        // 48-bit wrap
        wr(CLO, 32'hFFFF_FFFF);
        wr(CHI, 32'h0000_FFFF);
        wr(ENS, 32'h8000_0000);
        pulse(16'h0008);
        pulse(16'h0020);
        chk_rd("R9 wrap low", CLO, 32'h0);
        chk_rd("R9 wrap high", CHI, 32'h0);
        chk_rd("R9 wrap flag", OVS, 32'h8000_0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule